// File: doc/BRIEF.md
# Variable Bit Field Insert Unit

This block writes the low `size` bits of a 32-bit source word into a bit field of arbitrary alignment. The field sits either in memory or in a pair of general registers. In memory mode it is located by a base byte address and a signed bit position. The unit turns that pair into an aligned longword address and a bit offset within that longword. It then reads the one or two longwords that hold the field, merges the source bits in, and writes back exactly the longwords it read. In register mode the position is an offset into register n, and a field that runs past bit 31 spills into register n+1.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the unit is idle, and a command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. Once a command is taken, the unit exerts back-pressure by holding `cmd_ready` low until it returns to idle. A command ends in one of two ways:
- a single-cycle `done` pulse, which in register mode also carries the new register values and their write enables;
- a single-cycle `fault` pulse for an illegal size or register position, raised before any memory traffic.

The memory side is a plain request/acknowledge longword port. The unit has no condition-flag outputs, so flags cannot be disturbed.

Top module: `insv_unit`

## Requirements
- R1: `cmd_ready` is 1 only in the idle state. From the cycle after a command is accepted until the cycle after its `done` or `fault` pulse, `cmd_ready` is 0 and no further command is taken.
- R2: In memory mode the field's byte address is `cmd_base + (cmd_pos >>> 3)`, with the position treated as a signed two's-complement value. The longword address is that byte address with bits [1:0] cleared. The bit offset is `8*byte_address[1:0] + cmd_pos[2:0]`.
- R3: When offset + size − 1 ≤ 31, exactly two memory transfers occur: a read of the longword address, then a write to the same address.
- R4: When offset + size − 1 > 31, exactly four transfers occur, in this order: read A, read A+4, write A, write A+4.
- R5: In the 64-bit window {word at A+4, word at A}, bits offset .. offset+size−1 take `cmd_src[size-1:0]`, and every other bit keeps its old value.
- R6: Size 32 at offset 0 replaces the whole longword with `cmd_src`. Size 32 at a nonzero offset spans both longwords.
- R7: Size 0 gives a `done` pulse in the cycle after acceptance, with no memory transfer, no register write and no fault. This holds in register mode even when the position is above 31.
- R8: Sizes 33 to 255 give a `fault` pulse in the cycle after acceptance, with no memory transfer and no `done`.
- R9: In register mode the offset is `cmd_pos[4:0]`. The `done` cycle asserts `reg_we_lo`, with `reg_lo_out` as the new register n. It also asserts `reg_we_hi` with `reg_hi_out` as the new register n+1 only when offset + size − 1 > 31.
- R10: In register mode a position that is 32 or more as an unsigned value, negative values included, gives a `fault` pulse in the cycle after acceptance.
- R11: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. A transfer happens on a cycle with both high, and `mem_rdata` is taken in that cycle.
- R12: `done` pulses in the cycle after the final write's acknowledge. `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_src | input | 32 | Source bits to insert |
| cmd_pos | input | 32 | Bit position (signed in memory mode) |
| cmd_size | input | 8 | Field width in bits |
| cmd_base | input | 32 | Base byte address (memory mode) |
| cmd_regmode | input | 1 | 1 selects the register-pair target |
| cmd_reg_lo | input | 32 | Current register n (register mode) |
| cmd_reg_hi | input | 32 | Current register n+1 (register mode) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Longword-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | Command completed (pulse) |
| fault | output | 1 | Reserved-operand fault (pulse) |
| reg_we_lo | output | 1 | Write `reg_lo_out` to register n |
| reg_we_hi | output | 1 | Write `reg_hi_out` to register n+1 |
| reg_lo_out | output | 32 | New value of register n |
| reg_hi_out | output | 32 | New value of register n+1 |

## Verification
The hardest situation to reach is a field that crosses a longword boundary, with its bit offset coming from a misaligned base byte address combined with a negative position. Only then do the address carry, the four-transfer order and the high half of the merge all matter together.

The stimulus reaches it by choosing base and position pairs whose byte address lands in lanes 1 to 3, with a negative position that steps back across a longword. The memory responder then stalls each transfer for several cycles, so that request holding and the timing of the final acknowledge are exercised on the same spanning case.

// File: rtl/insv_pkg.sv
package insv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN,
    ST_FLT
  } insv_state_t;
endpackage

// File: rtl/insv_locate.sv
module insv_locate #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int POS_W  = 32,
  parameter int SIZE_W = 8,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(DATA_W),
  localparam int END_W  = OFF_W + 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [POS_W-1:0]  pos,
  input  logic [SIZE_W-1:0] size,
  input  logic              regmode,
  output logic [ADDR_W-1:0] lw_addr,
  output logic [OFF_W-1:0]  offset,
  output logic              span2,
  output logic              zero_size,
  output logic              bad_size,
  output logic              bad_regpos
);
  logic signed [POS_W-1:0] pos_s;
  logic signed [POS_W-1:0] byte_step;
  logic [ADDR_W-1:0]       byte_addr;
  logic [OFF_W-1:0]        mem_off;
  logic [END_W-1:0]        end_bit;

  assign pos_s     = $signed(pos);
  assign byte_step = pos_s >>> 3;
  assign byte_addr = base + ADDR_W'(byte_step);
  assign lw_addr   = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_off   = {byte_addr[LANE_W-1:0], pos[2:0]};
  assign offset    = regmode ? pos[OFF_W-1:0] : mem_off;

  // last bit touched, relative to the low longword
  assign end_bit    = END_W'(offset) + END_W'(size[OFF_W:0]) - END_W'(1);
  assign span2      = end_bit >= END_W'(DATA_W);
  assign zero_size  = (size == '0);
  assign bad_size   = size > SIZE_W'(DATA_W);
  assign bad_regpos = regmode && (pos >= POS_W'(DATA_W));
endmodule

// File: rtl/insv_merge.sv
module insv_merge #(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int WIN_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] old_lo,
  input  logic [DATA_W-1:0] old_hi,
  input  logic [DATA_W-1:0] src,
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W:0]    size_n,
  output logic [DATA_W-1:0] new_lo,
  output logic [DATA_W-1:0] new_hi
);
  logic [WIN_W-1:0] ones, mask, placed, window, merged;

  // a full-width field needs no special path: the window is twice as wide
  assign ones   = (WIN_W'(1) << size_n) - WIN_W'(1);
  assign mask   = ones << offset;
  assign placed = {{DATA_W{1'b0}}, src} << offset;
  assign window = {old_hi, old_lo};
  assign merged = (window & ~mask) | (placed & mask);
  assign new_lo = merged[DATA_W-1:0];
  assign new_hi = merged[WIN_W-1:DATA_W];
endmodule

// File: rtl/insv_unit.sv
module insv_unit
  import insv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int POS_W  = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_src,
  input  logic [POS_W-1:0]  cmd_pos,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic              cmd_regmode,
  input  logic [DATA_W-1:0] cmd_reg_lo,
  input  logic [DATA_W-1:0] cmd_reg_hi,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic              reg_we_lo,
  output logic              reg_we_hi,
  output logic [DATA_W-1:0] reg_lo_out,
  output logic [DATA_W-1:0] reg_hi_out
);
  localparam int OFF_W    = $clog2(DATA_W);
  localparam int LW_BYTES = DATA_W / 8;

  insv_state_t       st;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W:0]    size_q;
  logic              span_q, regmode_q, active_q;
  logic [DATA_W-1:0] src_q, lo_q, hi_q;

  logic [ADDR_W-1:0] loc_addr;
  logic [OFF_W-1:0]  loc_off;
  logic              loc_span, loc_zero, loc_bad_size, loc_bad_pos;
  logic [DATA_W-1:0] new_lo, new_hi;
  logic              take, xfer;

  insv_locate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W), .SIZE_W(SIZE_W)
  ) u_locate (
    .base       (cmd_base),
    .pos        (cmd_pos),
    .size       (cmd_size),
    .regmode    (cmd_regmode),
    .lw_addr    (loc_addr),
    .offset     (loc_off),
    .span2      (loc_span),
    .zero_size  (loc_zero),
    .bad_size   (loc_bad_size),
    .bad_regpos (loc_bad_pos)
  );

  insv_merge #(.DATA_W(DATA_W)) u_merge (
    .old_lo (lo_q),
    .old_hi (hi_q),
    .src    (src_q),
    .offset (off_q),
    .size_n (size_q),
    .new_lo (new_lo),
    .new_hi (new_hi)
  );

  assign cmd_ready = (st == ST_IDLE);
  assign take      = cmd_valid && cmd_ready;
  assign mem_req   = (st == ST_RD_LO) || (st == ST_RD_HI) ||
                     (st == ST_WR_LO) || (st == ST_WR_HI);
  assign mem_we    = (st == ST_WR_LO) || (st == ST_WR_HI);
  assign mem_addr  = ((st == ST_RD_HI) || (st == ST_WR_HI)) ?
                     addr_q + ADDR_W'(LW_BYTES) : addr_q;
  assign mem_wdata = (st == ST_WR_HI) ? new_hi : new_lo;
  assign xfer      = mem_req && mem_ack;

  assign done       = (st == ST_FIN);
  assign fault      = (st == ST_FLT);
  assign reg_we_lo  = done && regmode_q && active_q;
  assign reg_we_hi  = reg_we_lo && span_q;
  assign reg_lo_out = new_lo;
  assign reg_hi_out = new_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      off_q     <= '0;
      size_q    <= '0;
      span_q    <= 1'b0;
      regmode_q <= 1'b0;
      active_q  <= 1'b0;
      src_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            addr_q    <= loc_addr;
            off_q     <= loc_off;
            size_q    <= cmd_size[OFF_W:0];
            span_q    <= loc_span;
            regmode_q <= cmd_regmode;
            src_q     <= cmd_src;
            lo_q      <= cmd_reg_lo;
            hi_q      <= cmd_reg_hi;
            active_q  <= 1'b0;
            if (loc_zero) begin
              st <= ST_FIN;
            end else if (loc_bad_size || loc_bad_pos) begin
              st <= ST_FLT;
            end else if (cmd_regmode) begin
              active_q <= 1'b1;
              st       <= ST_FIN;
            end else begin
              active_q <= 1'b1;
              hi_q     <= '0;
              st       <= ST_RD_LO;
            end
          end
        end
        ST_RD_LO: if (xfer) begin
          lo_q <= mem_rdata;
          st   <= span_q ? ST_RD_HI : ST_WR_LO;
        end
        ST_RD_HI: if (xfer) begin
          hi_q <= mem_rdata;
          st   <= ST_WR_LO;
        end
        ST_WR_LO: if (xfer) st <= span_q ? ST_WR_HI : ST_FIN;
        ST_WR_HI: if (xfer) st <= ST_FIN;
        ST_FIN:   st <= ST_IDLE;
        ST_FLT:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/insv_unit_chk.sv
module insv_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [SIZE_W-1:0] cmd_size,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              done,
  input logic              fault,
  input logic              reg_we_lo,
  input logic              reg_we_hi
);
  p_busy_blocks_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_ready);

  p_zero_size_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_size == '0) |=> (done && !mem_req && !reg_we_lo && !fault));

  p_big_size_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_size > SIZE_W'(DATA_W)) |=> (fault && !mem_req && !done));

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_hi_needs_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_hi |-> reg_we_lo);

  p_end_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
endmodule

bind insv_unit insv_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_size  (cmd_size),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .done      (done),
  .fault     (fault),
  .reg_we_lo (reg_we_lo),
  .reg_we_hi (reg_we_hi)
);

// File: tb/sim_insv_unit.sv
module sim_insv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_src = '0, cmd_pos = '0, cmd_base = '0;
  logic [7:0]  cmd_size = '0;
  logic        cmd_regmode = 1'b0;
  logic [31:0] cmd_reg_lo = '0, cmd_reg_hi = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, fault, reg_we_lo, reg_we_hi;
  logic [31:0] reg_lo_out, reg_hi_out;

  always #4 clk = ~clk;

  insv_unit u0 (.*);

  int compared = 0, mismatched = 0;
  logic [31:0] mem [16];
  logic [31:0] snap [16];
  int          log_n, stall_cfg = 0, neg_cnt = 0, last_ack_neg = 0;
  logic        log_we [8];
  logic [31:0] log_addr [8];
  int          end_neg, accept_neg;
  logic        got_done, got_fault, got_we_lo, got_we_hi, busy_ready;
  logic [31:0] got_lo, got_hi;

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // memory responder: ack after stall_cfg wait cycles, logs every transfer
  initial begin
    int stall_left = 0;
    for (int i = 0; i < 16; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (32'h00FF00FF << i);
    forever begin
      @(negedge clk);
      neg_cnt++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        stall_left = stall_cfg;
      end else if (mem_req) begin
        if (stall_left > 0) stall_left--;
        else begin
          mem_ack = 1'b1;
          if (log_n < 8) begin
            log_we[log_n] = mem_we;
            log_addr[log_n] = mem_addr;
          end
          log_n++;
          last_ack_neg = neg_cnt;
          if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[5:2]];
        end
      end else stall_left = stall_cfg;
    end
  end

  task automatic run_cmd(input logic [31:0] src, input logic [31:0] pos, input logic [7:0] size,
                         input logic [31:0] base, input logic rm, input logic [31:0] rlo, input logic [31:0] rhi);
    int guard = 0;
    for (int i = 0; i < 16; i++) snap[i] = mem[i];
    log_n = 0;
    busy_ready = 1'b0;
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_src = src; cmd_pos = pos; cmd_size = size;
    cmd_base = base; cmd_regmode = rm; cmd_reg_lo = rlo; cmd_reg_hi = rhi;
    @(negedge clk); #1;
    accept_neg = neg_cnt;
    cmd_valid = 1'b0;
    while (!done && !fault && guard < 200) begin
      if (cmd_ready) busy_ready = 1'b1;
      @(negedge clk); #1;
      guard++;
    end
    end_neg = neg_cnt;
    got_done = done; got_fault = fault;
    got_we_lo = reg_we_lo; got_we_hi = reg_we_hi;
    got_lo = reg_lo_out; got_hi = reg_hi_out;
    if (cmd_ready) busy_ready = 1'b1;
    @(negedge clk); #1;
    check("R1", "ready back after end", cmd_ready, 1);
  endtask

  function automatic logic [63:0] put_bits(input logic [63:0] w, input logic [31:0] src, input int off, input int size);
    logic [63:0] r = w;
    for (int i = 0; i < size; i++) r[off + i] = src[i];
    return r;
  endfunction

  task automatic mem_case(input string req, input logic [31:0] src, input logic [31:0] pos,
                          input logic [7:0] size, input logic [31:0] base);
    logic [31:0] ba, la;
    int off, idx, nx;
    logic two;
    logic [63:0] win;
    logic [31:0] expm [16];
    ba  = base + 32'($signed(pos) >>> 3);
    la  = ba & ~32'd3;
    off = int'(ba[1:0]) * 8 + int'(pos[2:0]);
    two = (off + int'(size) - 1) > 31;
    idx = int'(la[5:2]);
    for (int i = 0; i < 16; i++) expm[i] = mem[i];
    win = {expm[idx + 1], expm[idx]};
    win = put_bits(win, src, off, int'(size));
    expm[idx] = win[31:0];
    if (two) expm[idx + 1] = win[63:32];
    run_cmd(src, pos, size, base, 1'b0, '0, '0);
    check(req, "done", got_done, 1);
    check(req, "no fault", got_fault, 0);
    check("R1", "ready low while busy", busy_ready, 0);
    check(req, "transfer count", log_n, two ? 4 : 2);
    check("R2", "first read addr", log_addr[0], la);
    check(req, "first is read", log_we[0], 0);
    if (two) begin
      check("R4", "second read addr", log_addr[1], la + 4);
      check("R4", "order rd,rd,wr,wr", {log_we[1], log_we[2], log_we[3]}, 3'b011);
      check("R4", "write lo addr", log_addr[2], la);
      check("R4", "write hi addr", log_addr[3], la + 4);
    end else begin
      check("R3", "write addr", log_addr[1], la);
      check("R3", "second is write", log_we[1], 1);
    end
    for (int i = 0; i < 16; i++) check(req, $sformatf("word %0d", i), mem[i], expm[i]);
    check("R12", "done one cycle after last ack", end_neg, last_ack_neg + 1);
  endtask

  task automatic t_reset;
    check("R1", "reset ready", cmd_ready, 1);
    check("R11", "reset no req", mem_req, 0);
    check("R12", "reset no done", done, 0);
    check("R8", "reset no fault", fault, 0);
  endtask

  task automatic t_size_zero;
    run_cmd(32'hFFFFFFFF, 32'd12, 8'd0, 32'h10, 1'b0, '0, '0);
    check("R7", "done", got_done, 1);
    check("R7", "immediate", end_neg, accept_neg);
    check("R7", "no transfers", log_n, 0);
    for (int i = 0; i < 16; i++) check("R7", "memory unchanged", mem[i], snap[i]);
    run_cmd(32'hFFFFFFFF, 32'd40, 8'd0, '0, 1'b1, 32'h1234, 32'h5678);
    check("R7", "reg done", got_done, 1);
    check("R7", "reg no fault", got_fault, 0);
    check("R7", "reg no write", {got_we_lo, got_we_hi}, 2'b00);
  endtask

  task automatic t_big_size;
    run_cmd(32'h1, 32'd0, 8'd33, 32'h10, 1'b0, '0, '0);
    check("R8", "size 33 fault", {got_fault, got_done}, 2'b10);
    check("R8", "size 33 immediate", end_neg, accept_neg);
    check("R8", "size 33 no transfers", log_n, 0);
    run_cmd(32'h1, 32'd0, 8'd255, 32'h10, 1'b0, '0, '0);
    check("R8", "size 255 fault", {got_fault, got_done}, 2'b10);
    check("R8", "size 255 no transfers", log_n, 0);
    for (int i = 0; i < 16; i++) check("R8", "memory unchanged", mem[i], snap[i]);
  endtask

  task automatic t_regs;
    logic [63:0] e;
    e = put_bits({32'hCAFEF00D, 32'h0F0F0F0F}, 32'hFFFFFF2D, 3, 6);
    run_cmd(32'hFFFFFF2D, 32'd3, 8'd6, '0, 1'b1, 32'h0F0F0F0F, 32'hCAFEF00D);
    check("R9", "single done", got_done, 1);
    check("R9", "single enables", {got_we_lo, got_we_hi}, 2'b10);
    check("R9", "single lo", got_lo, e[31:0]);
    check("R9", "no transfers", log_n, 0);
    e = put_bits({32'h00000000, 32'hFFFFFFFF}, 32'h000000A5, 30, 8);
    run_cmd(32'h000000A5, 32'd30, 8'd8, '0, 1'b1, 32'hFFFFFFFF, 32'h00000000);
    check("R9", "span enables", {got_we_lo, got_we_hi}, 2'b11);
    check("R9", "span lo", got_lo, e[31:0]);
    check("R9", "span hi", got_hi, e[63:32]);
    run_cmd(32'h1, 32'd32, 8'd4, '0, 1'b1, '0, '0);
    check("R10", "pos 32 fault", {got_fault, got_done, got_we_lo}, 3'b100);
    run_cmd(32'h1, 32'hFFFFFFFF, 8'd4, '0, 1'b1, '0, '0);
    check("R10", "pos -1 fault", {got_fault, got_done}, 2'b10);
    check("R10", "no transfers", log_n, 0);
  endtask

  initial begin
    bit finished = 0;
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        mem_case("R3", 32'h000000A7, 32'd4, 8'd8, 32'h10);
        mem_case("R5", 32'hFFFFF123, 32'd28, 8'd12, 32'h10);
        mem_case("R2", 32'h000002AB, 32'hFFFFFFFB, 8'd10, 32'h20);
        mem_case("R2", 32'h0000001F, 32'd13, 8'd5, 32'h0A);
        mem_case("R6", 32'hDEADBEEF, 32'd0, 8'd32, 32'h30);
        mem_case("R6", 32'h13579BDF, 32'd8, 8'd32, 32'h30);
        t_size_zero();
        t_big_size();
        t_regs();
        stall_cfg = 3;
        mem_case("R11", 32'h5A5A5A5A, 32'hFFFFFFF3, 8'd20, 32'h1D);
        mem_case("R11", 32'h00000ACE, 32'd9, 8'd12, 32'h04);
        stall_cfg = 0;
        finished = 1;
      end
      begin
        repeat (100000) @(posedge clk);
      end
    join_any
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule